// File: doc/BRIEF.md
# Dual-Bank Nonce Range Serializer

This block divides the 32-bit nonce search space among hashing chips that sit in two banks and share one serial configuration stream. When a start pulse arrives, it takes the configured chip count and works out the number of chips per bank. It then computes a start nonce for each chip position inside a bank. Only one table of per-position values is built. Each value goes out most significant bit first on two data lanes, one lane per bank.

Both lanes carry the same bits with one exception. In the top bit position of every value, the first bank's lane drives 0 and the second bank's lane drives 1. The first bank therefore searches the lower half of the nonce space and the second bank searches the upper half, without a second table. A data-valid strobe covers the whole transfer and a one-cycle done pulse marks its end. The block also reports a per-chip work timeout count derived from the bank size.

Top module: `nonce_split_serializer`

## Requirements
- R1: When a start is accepted, the block loads `bank_size` with floor((chip_count + 1) / 2). A 16-chip count gives 8 and a 15-chip count also gives 8.
- R2: A bank size that is zero, not a power of two, or above MAX_BANK is rejected. In that case `cfg_err` goes to 1 in the cycle after the start, `data_valid` stays 0, and `bank_size` keeps its previous value. An accepted start clears `cfg_err`.
- R3: Entries are sent in index order starting at 0. Entry i has the value i * 2^31 / bank_size. For a bank size of 8 this gives 0x00000000, 0x10000000, up to 0x70000000, and these values appear on `lane_a`.
- R4: In bit position 31 of every entry, `lane_a` is 0 and `lane_b` is 1. All other bits are identical on the two lanes. As a result, the 2 x bank_size received values are all distinct: the `lane_a` values are below 2^31 and the `lane_b` values are at or above 2^31.
- R5: Each value is sent MSB first. The lanes present one bit and advance only on a clock edge where `bit_en` is 1. The lanes hold steady while `bit_en` is 0.
- R6: `data_valid` is 1 from the cycle after an accepted start until the edge that consumes the last bit of the last entry. While `data_valid` is 0, both lanes are 0.
- R7: `done` is 1 for exactly one cycle, the cycle after the edge that consumes the last bit of the last entry.
- R8: A start that arrives while a transfer is in progress is ignored. The transfer, `bank_size`, `cfg_err` and `tick_limit` are unchanged.
- R9: A synchronous reset returns the block to idle with both lanes, `data_valid`, `done`, `cfg_err`, `bank_size` and `tick_limit` at 0.
- R10: An accepted start loads `tick_limit` with TICK_BASE / bank_size / 2, rounded down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a transfer (sampled only when idle) |
| chip_count | input | CW | Number of chips on the board |
| bit_en | input | 1 | Advance to the next serial bit |
| lane_a | output | 1 | Serial data for the first bank |
| lane_b | output | 1 | Serial data for the second bank |
| data_valid | output | 1 | High for the whole transfer |
| done | output | 1 | One-cycle end-of-transfer pulse |
| cfg_err | output | 1 | Last start was rejected |
| bank_size | output | $clog2(MAX_BANK)+1 | Chips per bank from the last accepted start |
| tick_limit | output | TW | Per-chip work timeout count |

## Verification
The hardest situation to reach from the ports is a second start that lands in the middle of a transfer. The bench must show that this start has no effect. To do so, it raises start at a fixed cycle inside a long, throttled transfer, together with a chip count that would be rejected. It then checks that every received value, the bank size and the error flag still match the original configuration. The bench also sweeps every chip count from 0 to 20 under several `bit_en` patterns. Each received word on both lanes is rebuilt and checked for pairwise distinctness.

// File: rtl/nsr_pkg.sv
package nsr_pkg;
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_SEND = 1'b1
   } nsr_state_t;
endpackage

// File: rtl/nsr_bank_calc.sv
module nsr_bank_calc #(
   parameter int CW        = 5,
   parameter int MAX_BANK  = 8,
   parameter int TICK_BASE = 1000,
   parameter int TW        = 16,
   localparam int IW       = $clog2(MAX_BANK),
   localparam int BW       = IW + 1,
   localparam int LW       = IW
) (
   input  logic [CW-1:0] chip_count,
   output logic          cfg_ok,
   output logic [BW-1:0] bank_sz,
   output logic [LW-1:0] bank_log2,
   output logic [TW-1:0] tick
);
   localparam int SW = CW + 1;

   if (SW < BW + 1) begin : g_chk_cw
      $error("chip count width too small for MAX_BANK");
   end

   logic [SW-1:0] half;
   assign half    = ({1'b0, chip_count} + SW'(1)) >> 1;
   assign bank_sz = half[BW-1:0];

   always_comb begin
      cfg_ok    = 1'b0;
      bank_log2 = '0;
      for (int k = 0; k <= IW; k++) begin
         if (half == SW'(1 << k)) begin
            cfg_ok    = 1'b1;
            bank_log2 = LW'(k);
         end
      end
   end

   assign tick = TW'(TICK_BASE >> (int'(bank_log2) + 1));
endmodule

// File: rtl/nsr_range_gen.sv
module nsr_range_gen #(
   parameter int NONCE_W  = 32,
   parameter int MAX_BANK = 8,
   localparam int IW      = $clog2(MAX_BANK),
   localparam int LW      = IW
) (
   input  logic [IW-1:0]      entry,
   input  logic [LW-1:0]      bank_log2,
   output logic [NONCE_W-1:0] value
);
   logic [NONCE_W-1:0] base;
   assign base  = {{(NONCE_W-IW){1'b0}}, entry};
   assign value = base << (NONCE_W - 1 - int'(bank_log2));
endmodule

// File: rtl/nsr_shift_ctrl.sv
module nsr_shift_ctrl
   import nsr_pkg::*;
#(
   parameter int NONCE_W  = 32,
   parameter int MAX_BANK = 8,
   localparam int IW      = $clog2(MAX_BANK),
   localparam int BI      = $clog2(NONCE_W)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          launch,
   input  logic          bit_en,
   input  logic [IW-1:0] last_entry,
   output logic          busy,
   output logic          done,
   output logic [IW-1:0] entry,
   output logic [BI-1:0] bit_idx
);
   localparam logic [BI-1:0] MSB = BI'(NONCE_W - 1);

   nsr_state_t st;

   always_ff @(posedge clk) begin
      if (rst) begin
         st      <= ST_IDLE;
         bit_idx <= MSB;
         entry   <= '0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (st)
            ST_IDLE: if (launch) begin
               st      <= ST_SEND;
               bit_idx <= MSB;
               entry   <= '0;
            end
            ST_SEND: if (bit_en) begin
               if (bit_idx == '0) begin
                  bit_idx <= MSB;
                  if (entry == last_entry) begin
                     st   <= ST_IDLE;
                     done <= 1'b1;
                  end else begin
                     entry <= entry + IW'(1);
                  end
               end else begin
                  bit_idx <= bit_idx - BI'(1);
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy = (st == ST_SEND);

   p_hold_r5: assert property (@(posedge clk) disable iff (rst)
      busy && !bit_en |=> $stable(bit_idx) && $stable(entry));
   p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);
   p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
      done |-> !busy);
endmodule

// File: rtl/nonce_split_serializer.sv
module nonce_split_serializer #(
   parameter int NONCE_W   = 32,
   parameter int CW        = 5,
   parameter int MAX_BANK  = 8,
   parameter int TICK_BASE = 1000,
   parameter int TW        = 16,
   localparam int IW       = $clog2(MAX_BANK),
   localparam int BW       = IW + 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start,
   input  logic [CW-1:0] chip_count,
   input  logic          bit_en,
   output logic          lane_a,
   output logic          lane_b,
   output logic          data_valid,
   output logic          done,
   output logic          cfg_err,
   output logic [BW-1:0] bank_size,
   output logic [TW-1:0] tick_limit
);
   localparam int LW = IW;
   localparam int BI = $clog2(NONCE_W);

   if (MAX_BANK < 2 || (1 << IW) != MAX_BANK) begin : g_chk_bank
      $error("MAX_BANK must be a power of two of at least 2");
   end
   if (NONCE_W <= IW + 1) begin : g_chk_w
      $error("NONCE_W too small");
   end

   logic          calc_ok;
   logic [BW-1:0] calc_bank;
   logic [LW-1:0] calc_log2;
   logic [TW-1:0] calc_tick;

   nsr_bank_calc #(.CW(CW), .MAX_BANK(MAX_BANK), .TICK_BASE(TICK_BASE), .TW(TW)) u_calc (
      .chip_count(chip_count), .cfg_ok(calc_ok), .bank_sz(calc_bank),
      .bank_log2(calc_log2), .tick(calc_tick));

   logic          busy;
   logic          accept;
   logic [LW-1:0] log2_q;
   logic [IW-1:0] entry;
   logic [BI-1:0] bit_idx;
   logic [NONCE_W-1:0] value;

   assign accept = start && !busy;

   always_ff @(posedge clk) begin
      if (rst) begin
         cfg_err    <= 1'b0;
         bank_size  <= '0;
         tick_limit <= '0;
         log2_q     <= '0;
      end else if (accept) begin
         cfg_err <= !calc_ok;
         if (calc_ok) begin
            bank_size  <= calc_bank;
            tick_limit <= calc_tick;
            log2_q     <= calc_log2;
         end
      end
   end

   logic [IW-1:0] last_entry;
   assign last_entry = IW'((1 << log2_q) - 1);

   nsr_shift_ctrl #(.NONCE_W(NONCE_W), .MAX_BANK(MAX_BANK)) u_ctrl (
      .clk(clk), .rst(rst), .launch(accept && calc_ok), .bit_en(bit_en),
      .last_entry(last_entry), .busy(busy), .done(done),
      .entry(entry), .bit_idx(bit_idx));

   nsr_range_gen #(.NONCE_W(NONCE_W), .MAX_BANK(MAX_BANK)) u_range (
      .entry(entry), .bank_log2(log2_q), .value(value));

   logic [1:0] lane_bits;
   for (genvar l = 0; l < 2; l++) begin : g_lane
      always_comb begin
         if (!busy)
            lane_bits[l] = 1'b0;
         else if (bit_idx == BI'(NONCE_W - 1))
            lane_bits[l] = 1'(l);
         else
            lane_bits[l] = value[bit_idx];
      end
   end

   assign lane_a     = lane_bits[0];
   assign lane_b     = lane_bits[1];
   assign data_valid = busy;

   p_idle_low_r6: assert property (@(posedge clk) disable iff (rst)
      !data_valid |-> !lane_a && !lane_b);
   p_top_split_r4: assert property (@(posedge clk) disable iff (rst)
      data_valid && bit_idx == BI'(NONCE_W - 1) |-> !lane_a && lane_b);
   p_lane_match_r4: assert property (@(posedge clk) disable iff (rst)
      data_valid && bit_idx != BI'(NONCE_W - 1) |-> lane_a == lane_b);
   p_err_no_send_r2: assert property (@(posedge clk) disable iff (rst)
      cfg_err |-> !data_valid);
   p_ignore_r8: assert property (@(posedge clk) disable iff (rst)
      data_valid && start |=> $stable(bank_size) && $stable(cfg_err));
   p_launch_r6: assert property (@(posedge clk) disable iff (rst)
      accept && calc_ok |=> data_valid);
endmodule

// File: tb/sim_nonce_split_serializer.sv
module sim_nonce_split_serializer;
   localparam int CW = 5;
   localparam int TB = 1000;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic start = 1'b0;
   logic [CW-1:0] chip_count = '0;
   logic bit_en = 1'b0;
   logic lane_a, lane_b, data_valid, done, cfg_err;
   logic [3:0] bank_size;
   logic [15:0] tick_limit;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   nonce_split_serializer #(.NONCE_W(32), .CW(CW), .MAX_BANK(8), .TICK_BASE(TB), .TW(16)) u0 (
      .clk(clk), .rst(rst), .start(start), .chip_count(chip_count), .bit_en(bit_en),
      .lane_a(lane_a), .lane_b(lane_b), .data_valid(data_valid), .done(done),
      .cfg_err(cfg_err), .bank_size(bank_size), .tick_limit(tick_limit));

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic bit en_pat(input int mode, input int c);
      case (mode)
         0: return 1'b1;
         1: return (c % 2) == 1;
         default: return (c % 5) != 2 && (c % 7) != 0;
      endcase
   endfunction

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         fails++;
         $display("FAIL watchdog actual=%0d expected<=100000", cycles);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   task automatic run_cfg(input int n, input int mode, input bit inject);
      int eb, lg, total, taken, c;
      bit valid;
      logic [31:0] a_acc, b_acc;
      logic [31:0] aw [8];
      logic [31:0] bw [8];
      logic pa, pb;
      int prev_bank, prev_err;
      prev_bank = bank_size;
      prev_err  = cfg_err;
      eb = (n + 1) / 2;
      valid = (eb == 1 || eb == 2 || eb == 4 || eb == 8);
      lg = (eb == 8) ? 3 : (eb == 4) ? 2 : (eb == 2) ? 1 : 0;
      @(negedge clk);
      chip_count = CW'(n);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (!valid) begin
         check(cfg_err == 1'b1, "R2 err flag", cfg_err, 1);
         check(bank_size == 4'(prev_bank), "R2 bank kept", bank_size, prev_bank);
         for (int k = 0; k < 3; k++) begin
            check(data_valid == 1'b0 && !lane_a && !lane_b, "R2 no transfer", data_valid, 0);
            @(negedge clk);
         end
         return;
      end
      check(cfg_err == 1'b0, "R2 err cleared", cfg_err, 0);
      check(bank_size == 4'(eb), "R1 bank size", bank_size, eb);
      check(tick_limit == 16'(TB / eb / 2), "R10 tick limit", tick_limit, TB / eb / 2);
      total = eb * 32;
      taken = 0;
      c = 0;
      pa = 1'b0;
      pb = 1'b0;
      a_acc = '0;
      b_acc = '0;
      while (taken < total) begin
         bit_en = en_pat(mode, c);
         if (inject && c == 40) begin
            start = 1'b1;
            chip_count = CW'(5);
         end
         if (data_valid !== 1'b1) check(1'b0, "R6 valid during transfer", data_valid, 1);
         if (c > 0 && !en_pat(mode, c - 1) && (lane_a !== pa || lane_b !== pb))
            check(1'b0, "R5 lanes hold", {lane_a, lane_b}, {pa, pb});
         pa = lane_a;
         pb = lane_b;
         if (bit_en) begin
            a_acc = {a_acc[30:0], lane_a};
            b_acc = {b_acc[30:0], lane_b};
            if (taken % 32 == 31) begin
               aw[taken / 32] = a_acc;
               bw[taken / 32] = b_acc;
            end
            taken++;
         end
         @(negedge clk);
         start = 1'b0;
         c++;
      end
      bit_en = 1'b0;
      check(done == 1'b1, "R7 done after last bit", done, 1);
      check(data_valid == 1'b0 && !lane_a && !lane_b, "R6 valid drops", data_valid, 0);
      @(negedge clk);
      check(done == 1'b0, "R7 done one cycle", done, 0);
      for (int i = 0; i < eb; i++) begin
         logic [31:0] ea;
         ea = 32'(i) << (31 - lg);
         check(aw[i] == ea, "R3 lane_a entry", aw[i], ea);
         check(bw[i] == (ea | 32'h8000_0000), "R4 lane_b entry", bw[i], ea | 32'h8000_0000);
      end
      begin
         bit dis;
         dis = 1'b1;
         for (int i = 0; i < eb; i++) begin
            if (aw[i][31] || !bw[i][31]) dis = 1'b0;
            for (int j = 0; j < eb; j++) begin
               if (aw[i] == bw[j]) dis = 1'b0;
               if (i != j && (aw[i] == aw[j] || bw[i] == bw[j])) dis = 1'b0;
            end
         end
         check(dis, "R4 ranges disjoint", dis, 1);
      end
      if (inject) begin
         check(cfg_err == 1'b0, "R8 err unchanged", cfg_err, 0);
         check(bank_size == 4'(eb), "R8 bank unchanged", bank_size, eb);
         check(tick_limit == 16'(TB / eb / 2), "R8 tick unchanged", tick_limit, TB / eb / 2);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(!lane_a && !lane_b && !data_valid && !done, "R9 reset outputs", {lane_a, lane_b, data_valid, done}, 0);
      check(bank_size == 0 && tick_limit == 0 && !cfg_err, "R9 reset config", bank_size, 0);
      rst = 1'b0;
      for (int n = 0; n <= 20; n++) run_cfg(n, n % 3, 1'b0);
      run_cfg(16, 2, 1'b1);
      run_cfg(8, 1, 1'b1);
      run_cfg(15, 0, 1'b0);
      @(negedge clk);
      chip_count = CW'(16);
      start = 1'b1;
      bit_en = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (10) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      check(!lane_a && !lane_b && !data_valid && !done, "R9 mid-transfer reset", {lane_a, lane_b, data_valid}, 0);
      check(bank_size == 0 && !cfg_err, "R9 reset clears bank", bank_size, 0);
      rst = 1'b0;
      bit_en = 1'b0;
      @(negedge clk);
      check(!data_valid, "R9 stays idle", data_valid, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule